// File: doc/BRIEF.md
# Dependence-Steered FIFO Issue Queues

This block holds renamed instructions waiting to issue. It does not use one associative window where every entry watches every result tag. Instead it uses a small set of in-order FIFO lanes, and each lane is meant to hold a chain of instructions that depend on one another. At dispatch, a steering stage picks the lane for the incoming instruction. It reads a per-register producer-location table, which says which lane holds the producer of each physical register. When an operand's producer is the youngest entry of a lane, the new instruction is appended behind it. Otherwise the instruction starts a new chain in an empty lane. If no lane qualifies, dispatch stalls.

A scoreboard of physical registers decides readiness. A register goes busy when an instruction that writes it is accepted, and it becomes ready again when its tag comes back on the writeback port. Only the oldest entry of each lane is examined. That lane raises its issue request when every source the entry uses is marked ready. An external selector grants lanes through per-lane pop inputs. A granted head leaves its lane. If that lane still owned the producer entry of the head's destination register, the entry is withdrawn.

Top module: `dep_fifo_issue`

## Requirements
- R1: After reset every lane is empty, no issue request is raised, every physical register is marked ready, and no register has a producer lane recorded.
- R2: A dispatched instruction is appended to lane q when a valid source register's recorded producer lane is q, the youngest entry of q writes that register, and q holds fewer than DEPTH entries. Source 0 is tried before source 1.
- R3: When R2 does not apply, the instruction goes to the lowest-numbered empty lane. When no lane is empty, `disp_stall` is high in that cycle and the dispatch changes no state.
- R4: `iss_req[q]` is high exactly when lane q is non-empty and every source its head marks valid is ready in the scoreboard. A source marked not valid does not affect the request.
- R5: An accepted dispatch with a valid destination marks that register busy from the next cycle. A writeback marks its tag ready from the next cycle. When both name the same register in one cycle, the register ends up busy.
- R6: A writeback in the same cycle as the dispatch of an instruction that reads that tag is not lost. If the instruction lands at the head of a lane, its request is high in the next cycle.
- R7: `iss_pop[q]` removes the head of lane q only while `iss_req[q]` is high, and the next entry is shown from the following cycle. A pop while the request is low is ignored and leaves the head unchanged.
- R8: When a head is removed and its destination's recorded producer lane is that lane, the record is cleared, so a later reader of that register starts a fresh chain. A dispatch in the same cycle that writes the same register records its own lane instead.
- R9: Each lane issues in dispatch order. A lane that is full is never appended to, and the instruction goes to an empty lane instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_src0 | input | TW | First source physical register |
| disp_src0_vld | input | 1 | First source is used |
| disp_src1 | input | TW | Second source physical register |
| disp_src1_vld | input | 1 | Second source is used |
| disp_dst | input | TW | Destination physical register |
| disp_dst_vld | input | 1 | Instruction writes a register |
| disp_stall | output | 1 | Offered instruction cannot be accepted this cycle |
| disp_qsel | output | QW | Lane chosen for the offered instruction |
| wb_valid | input | 1 | A result tag is written back |
| wb_tag | input | TW | Physical register written back |
| iss_req | output | NUM_Q | Per-lane head-ready issue request |
| iss_pop | input | NUM_Q | Per-lane grant that removes the head |
| iss_dst | output | NUM_Q*TW | Destination register of each lane head |
| iss_dst_vld | output | NUM_Q | Each lane head writes a register |

## Verification
`disp_stall` and `disp_qsel` are combinational, so they are compared in the same cycle the instruction is offered. Every other effect appears one edge later. A dispatch, writeback or pop changes the lane contents and the scoreboard at the clock edge, and `iss_req` and the head outputs are then compared in the following cycle. The bench drives its inputs on the falling edge and samples one time unit later. It steps a reference model only after the rising edge, so each expected value refers to the state that the edge just committed.

// File: rtl/dfq_pkg.sv
package dfq_pkg;
   typedef enum logic [1:0] {
      STEER_APPEND = 2'd0,
      STEER_FRESH  = 2'd1,
      STEER_HOLD   = 2'd2
   } steer_e;
endpackage

// File: rtl/dfq_lane.sv
module dfq_lane #(
   parameter int DEPTH    = 8,
   parameter int W        = 18,
   parameter int TAIL_LSB = 0,
   parameter int TAIL_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [W-1:0]      din,
   output logic [W-1:0]      head,
   output logic [TAIL_W-1:0] tail,
   output logic              empty,
   output logic              full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dfq_lane: DEPTH must be at least 2");
   end
   if (TAIL_LSB + TAIL_W > W) begin : g_bad_tail
      $error("dfq_lane: tail slice exceeds entry width");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt, wr_prev;
   logic [CW-1:0] cnt;
   logic          do_push, do_pop;
   logic [W-1:0]  tail_ent;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign rd_nxt  = rd_ptr + 1'b1;
      assign wr_nxt  = wr_ptr + 1'b1;
      assign wr_prev = wr_ptr - 1'b1;
   end else begin : g_wrap
      assign rd_nxt  = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      assign wr_nxt  = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign wr_prev = (wr_ptr == '0) ? PW'(DEPTH - 1) : wr_ptr - 1'b1;
   end

   assign empty    = (cnt == '0);
   assign full     = (cnt == CW'(DEPTH));
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign head     = mem[rd_ptr];
   assign tail_ent = mem[wr_prev];
   assign tail     = tail_ent[TAIL_LSB +: TAIL_W];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/dfq_ready_tbl.sv
module dfq_ready_tbl #(
   parameter int NPREG = 32,
   localparam int TW   = $clog2(NPREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [TW-1:0]    clr_tag,
   input  logic             set_en,
   input  logic [TW-1:0]    set_tag,
   output logic [NPREG-1:0] rdy
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy <= '1;
      end else begin
         if (set_en) rdy[set_tag] <= 1'b1;
         if (clr_en) rdy[clr_tag] <= 1'b0;
      end
   end
endmodule

// File: rtl/dfq_steer.sv
module dfq_steer
   import dfq_pkg::*;
#(
   parameter int NUM_Q = 4,
   parameter int NPREG = 32,
   localparam int TW   = $clog2(NPREG),
   localparam int QW   = $clog2(NUM_Q)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      disp_valid,
   input  logic [TW-1:0]             src0,
   input  logic                      src0_vld,
   input  logic [TW-1:0]             src1,
   input  logic                      src1_vld,
   input  logic [TW-1:0]             dst,
   input  logic                      dst_vld,
   input  logic [NUM_Q-1:0][TW-1:0]  tail_dst,
   input  logic [NUM_Q-1:0]          tail_dst_vld,
   input  logic [NUM_Q-1:0]          q_empty,
   input  logic [NUM_Q-1:0]          q_full,
   input  logic [NUM_Q-1:0]          q_pop,
   input  logic [NUM_Q-1:0][TW-1:0]  head_dst,
   input  logic [NUM_Q-1:0]          head_dst_vld,
   output logic [QW-1:0]             qsel,
   output logic                      accept,
   output logic                      stall
);
   logic          own_v [NPREG];
   logic [QW-1:0] own_q [NPREG];
   steer_e        dec;
   logic          hit0, hit1;
   logic [QW-1:0] q0, q1;

   always_comb begin
      q0   = own_q[src0];
      q1   = own_q[src1];
      hit0 = src0_vld && own_v[src0] && !q_empty[q0] && !q_full[q0]
             && tail_dst_vld[q0] && (tail_dst[q0] == src0);
      hit1 = src1_vld && own_v[src1] && !q_empty[q1] && !q_full[q1]
             && tail_dst_vld[q1] && (tail_dst[q1] == src1);
      dec  = STEER_HOLD;
      qsel = '0;
      if (hit0) begin
         dec  = STEER_APPEND;
         qsel = q0;
      end else if (hit1) begin
         dec  = STEER_APPEND;
         qsel = q1;
      end else begin
         for (int q = NUM_Q - 1; q >= 0; q--) begin
            if (q_empty[q]) begin
               dec  = STEER_FRESH;
               qsel = QW'(q);
            end
         end
      end
   end

   assign accept = disp_valid && (dec != STEER_HOLD);
   assign stall  = disp_valid && (dec == STEER_HOLD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NPREG; r++) begin
            own_v[r] <= 1'b0;
            own_q[r] <= '0;
         end
      end else begin
         for (int q = 0; q < NUM_Q; q++) begin
            if (q_pop[q] && head_dst_vld[q] && own_v[head_dst[q]]
                && (own_q[head_dst[q]] == QW'(q)))
               own_v[head_dst[q]] <= 1'b0;
         end
         if (accept && dst_vld) begin
            own_v[dst] <= 1'b1;
            own_q[dst] <= qsel;
         end
      end
   end
endmodule

// File: rtl/dep_fifo_issue.sv
module dep_fifo_issue #(
   parameter int NUM_Q = 4,
   parameter int DEPTH = 8,
   parameter int NPREG = 32,
   localparam int TW   = $clog2(NPREG),
   localparam int QW   = $clog2(NUM_Q)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     disp_valid,
   input  logic [TW-1:0]            disp_src0,
   input  logic                     disp_src0_vld,
   input  logic [TW-1:0]            disp_src1,
   input  logic                     disp_src1_vld,
   input  logic [TW-1:0]            disp_dst,
   input  logic                     disp_dst_vld,
   output logic                     disp_stall,
   output logic [QW-1:0]            disp_qsel,
   input  logic                     wb_valid,
   input  logic [TW-1:0]            wb_tag,
   output logic [NUM_Q-1:0]         iss_req,
   input  logic [NUM_Q-1:0]         iss_pop,
   output logic [NUM_Q-1:0][TW-1:0] iss_dst,
   output logic [NUM_Q-1:0]         iss_dst_vld
);
   localparam int D_LO  = 0;
   localparam int DV    = TW;
   localparam int S1_LO = TW + 1;
   localparam int S1V   = 2 * TW + 1;
   localparam int S0_LO = 2 * TW + 2;
   localparam int S0V   = 3 * TW + 2;
   localparam int EW    = 3 * TW + 3;

   if (NUM_Q < 2) begin : g_bad_q
      $error("dep_fifo_issue: NUM_Q must be at least 2");
   end
   if (NPREG != (1 << TW)) begin : g_bad_preg
      $error("dep_fifo_issue: NPREG must be a power of two");
   end

   logic [EW-1:0]             disp_ent;
   logic [NUM_Q-1:0][EW-1:0]  heads;
   logic [NUM_Q-1:0][TW:0]    tails;
   logic [NUM_Q-1:0][TW-1:0]  tail_dst;
   logic [NUM_Q-1:0]          tail_dst_vld;
   logic [NUM_Q-1:0]          q_empty, q_full, q_push, q_pop;
   logic [NPREG-1:0]          rdy_vec;
   logic                      accept;

   assign disp_ent = {disp_src0_vld, disp_src0, disp_src1_vld, disp_src1,
                      disp_dst_vld, disp_dst};

   dfq_steer #(.NUM_Q(NUM_Q), .NPREG(NPREG)) u_steer (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
      .src0(disp_src0), .src0_vld(disp_src0_vld),
      .src1(disp_src1), .src1_vld(disp_src1_vld),
      .dst(disp_dst), .dst_vld(disp_dst_vld),
      .tail_dst(tail_dst), .tail_dst_vld(tail_dst_vld),
      .q_empty(q_empty), .q_full(q_full), .q_pop(q_pop),
      .head_dst(iss_dst), .head_dst_vld(iss_dst_vld),
      .qsel(disp_qsel), .accept(accept), .stall(disp_stall)
   );

   dfq_ready_tbl #(.NPREG(NPREG)) u_rdy (
      .clk(clk), .rst_n(rst_n),
      .clr_en(accept && disp_dst_vld), .clr_tag(disp_dst),
      .set_en(wb_valid), .set_tag(wb_tag),
      .rdy(rdy_vec)
   );

   for (genvar q = 0; q < NUM_Q; q++) begin : g_lane
      logic [EW-1:0] h;
      assign q_push[q] = accept && (disp_qsel == QW'(q));
      assign q_pop[q]  = iss_pop[q] && iss_req[q];

      dfq_lane #(.DEPTH(DEPTH), .W(EW), .TAIL_LSB(D_LO), .TAIL_W(TW + 1)) u_lane (
         .clk(clk), .rst_n(rst_n), .push(q_push[q]), .pop(q_pop[q]),
         .din(disp_ent), .head(heads[q]), .tail(tails[q]),
         .empty(q_empty[q]), .full(q_full[q])
      );

      assign h               = heads[q];
      assign tail_dst[q]     = tails[q][TW-1:0];
      assign tail_dst_vld[q] = tails[q][TW];
      assign iss_dst[q]      = h[D_LO +: TW];
      assign iss_dst_vld[q]  = h[DV];
      assign iss_req[q]      = !q_empty[q]
                               && (!h[S0V] || rdy_vec[h[S0_LO +: TW]])
                               && (!h[S1V] || rdy_vec[h[S1_LO +: TW]]);
   end
endmodule

// File: rtl/dfq_checker.sv
module dfq_checker #(
   parameter int NUM_Q = 4,
   parameter int NPREG = 32,
   localparam int TW   = $clog2(NPREG)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     disp_valid,
   input logic                     disp_stall,
   input logic [TW-1:0]            disp_dst,
   input logic                     disp_dst_vld,
   input logic                     wb_valid,
   input logic [TW-1:0]            wb_tag,
   input logic [NUM_Q-1:0]         iss_req,
   input logic [NUM_Q-1:0]         iss_pop,
   input logic [NUM_Q-1:0][TW-1:0] iss_dst,
   input logic [NUM_Q-1:0]         iss_dst_vld,
   input logic [NPREG-1:0]         rdy
);
   AST_STALL_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
      disp_stall |-> disp_valid); // R3

   AST_DISP_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_stall && disp_dst_vld) |=> !rdy[$past(disp_dst)]); // R5

   AST_WB_MARKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !(disp_valid && !disp_stall && disp_dst_vld && disp_dst == wb_tag))
      |=> rdy[$past(wb_tag)]); // R5

   for (genvar q = 0; q < NUM_Q; q++) begin : g_lane_chk
      AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_req[q] && !iss_pop[q]) |=> ($stable(iss_dst[q]) && $stable(iss_dst_vld[q]))); // R7
   end
endmodule

bind dep_fifo_issue dfq_checker #(.NUM_Q(NUM_Q), .NPREG(NPREG)) u_chk (
   .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_stall(disp_stall),
   .disp_dst(disp_dst), .disp_dst_vld(disp_dst_vld),
   .wb_valid(wb_valid), .wb_tag(wb_tag),
   .iss_req(iss_req), .iss_pop(iss_pop),
   .iss_dst(iss_dst), .iss_dst_vld(iss_dst_vld), .rdy(rdy_vec)
);

// File: tb/sim_dep_fifo_issue.sv
module sim_dep_fifo_issue;
   localparam int CLK_PERIOD = 10;
   localparam int NQ = 4;
   localparam int DP = 8;
   localparam int NR = 32;
   localparam int WATCHDOG = 200000;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 disp_valid = 1'b0;
   logic [4:0]           disp_src0 = '0, disp_src1 = '0, disp_dst = '0;
   logic                 disp_src0_vld = 1'b0, disp_src1_vld = 1'b0, disp_dst_vld = 1'b0;
   logic                 disp_stall;
   logic [1:0]           disp_qsel;
   logic                 wb_valid = 1'b0;
   logic [4:0]           wb_tag = '0;
   logic [NQ-1:0]        iss_req;
   logic [NQ-1:0]        iss_pop = '0;
   logic [NQ-1:0][4:0]   iss_dst;
   logic [NQ-1:0]        iss_dst_vld;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   dep_fifo_issue #(.NUM_Q(NQ), .DEPTH(DP), .NPREG(NR)) u0 (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
      .disp_src0(disp_src0), .disp_src0_vld(disp_src0_vld),
      .disp_src1(disp_src1), .disp_src1_vld(disp_src1_vld),
      .disp_dst(disp_dst), .disp_dst_vld(disp_dst_vld),
      .disp_stall(disp_stall), .disp_qsel(disp_qsel),
      .wb_valid(wb_valid), .wb_tag(wb_tag),
      .iss_req(iss_req), .iss_pop(iss_pop),
      .iss_dst(iss_dst), .iss_dst_vld(iss_dst_vld)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   // reference model
   logic [4:0] m_s0 [NQ][DP], m_s1 [NQ][DP], m_d [NQ][DP];
   logic       m_s0v[NQ][DP], m_s1v[NQ][DP], m_dv[NQ][DP];
   int         m_cnt[NQ];
   logic       m_rdy[NR];
   logic       m_own_v[NR];
   int         m_own_q[NR];

   task automatic model_reset();
      for (int q = 0; q < NQ; q++) m_cnt[q] = 0;
      for (int r = 0; r < NR; r++) begin
         m_rdy[r] = 1'b1; m_own_v[r] = 1'b0; m_own_q[r] = 0;
      end
   endtask

   function automatic bit m_hit(logic [4:0] s, logic sv);
      int q;
      if (!sv || !m_own_v[s]) return 1'b0;
      q = m_own_q[s];
      if (m_cnt[q] == 0 || m_cnt[q] >= DP) return 1'b0;
      return m_dv[q][m_cnt[q]-1] && (m_d[q][m_cnt[q]-1] == s);
   endfunction

   // dec: 0 append, 1 fresh lane, 2 hold
   function automatic void m_steer(output int dec, output int qs);
      dec = 2; qs = 0;
      if (m_hit(disp_src0, disp_src0_vld)) begin dec = 0; qs = m_own_q[disp_src0]; end
      else if (m_hit(disp_src1, disp_src1_vld)) begin dec = 0; qs = m_own_q[disp_src1]; end
      else begin
         for (int q = NQ - 1; q >= 0; q--) if (m_cnt[q] == 0) begin dec = 1; qs = q; end
      end
   endfunction

   function automatic bit m_req(int q);
      if (m_cnt[q] == 0) return 1'b0;
      return (!m_s0v[q][0] || m_rdy[m_s0[q][0]]) && (!m_s1v[q][0] || m_rdy[m_s1[q][0]]);
   endfunction

   task automatic chk(bit ok, string lbl, string what, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", lbl, what, act, exp);
      end
   endtask

   task automatic set_idle();
      disp_valid = 1'b0; disp_src0_vld = 1'b0; disp_src1_vld = 1'b0; disp_dst_vld = 1'b0;
      wb_valid = 1'b0; iss_pop = '0;
   endtask

   task automatic set_disp(logic [4:0] s0, logic s0v, logic [4:0] s1, logic s1v,
                           logic [4:0] d, logic dv);
      disp_valid = 1'b1; disp_src0 = s0; disp_src0_vld = s0v;
      disp_src1 = s1; disp_src1_vld = s1v; disp_dst = d; disp_dst_vld = dv;
   endtask

   task automatic set_wb(logic [4:0] t);
      wb_valid = 1'b1; wb_tag = t;
   endtask

   // one cycle: inputs already driven after a falling edge
   task automatic step(string lbl);
      int dec, qs;
      bit acc;
      bit preq[NQ];
      #1;
      m_steer(dec, qs);
      acc = disp_valid && (dec != 2);
      chk(disp_stall == (disp_valid && dec == 2), lbl, "R3 stall", int'(disp_stall),
          int'(disp_valid && dec == 2));
      if (acc) chk(int'(disp_qsel) == qs, lbl, "R2/R3 lane", int'(disp_qsel), qs);
      for (int q = 0; q < NQ; q++) begin
         preq[q] = m_req(q);
         chk(iss_req[q] == preq[q], lbl, $sformatf("R4 req[%0d]", q), int'(iss_req[q]),
             int'(preq[q]));
         if (m_cnt[q] > 0) begin
            chk(iss_dst[q] == m_d[q][0] && iss_dst_vld[q] == m_dv[q][0], lbl,
                $sformatf("R9 head dst[%0d]", q), int'(iss_dst[q]), int'(m_d[q][0]));
         end
      end
      @(posedge clk);
      cycles++;
      // producer records: removals first, then this cycle's dispatch (R8)
      for (int q = 0; q < NQ; q++) begin
         if (iss_pop[q] && preq[q]) begin
            if (m_dv[q][0] && m_own_v[m_d[q][0]] && m_own_q[m_d[q][0]] == q)
               m_own_v[m_d[q][0]] = 1'b0;
            for (int k = 0; k < DP - 1; k++) begin
               m_s0[q][k] = m_s0[q][k+1]; m_s0v[q][k] = m_s0v[q][k+1];
               m_s1[q][k] = m_s1[q][k+1]; m_s1v[q][k] = m_s1v[q][k+1];
               m_d[q][k]  = m_d[q][k+1];  m_dv[q][k]  = m_dv[q][k+1];
            end
            m_cnt[q]--;
         end
      end
      if (acc) begin
         m_s0[qs][m_cnt[qs]] = disp_src0; m_s0v[qs][m_cnt[qs]] = disp_src0_vld;
         m_s1[qs][m_cnt[qs]] = disp_src1; m_s1v[qs][m_cnt[qs]] = disp_src1_vld;
         m_d[qs][m_cnt[qs]]  = disp_dst;  m_dv[qs][m_cnt[qs]]  = disp_dst_vld;
         m_cnt[qs]++;
         if (disp_dst_vld) begin m_own_v[disp_dst] = 1'b1; m_own_q[disp_dst] = qs; end
      end
      // R5: writeback sets, accepted destination clears and wins
      if (wb_valid) m_rdy[wb_tag] = 1'b1;
      if (acc && disp_dst_vld) m_rdy[disp_dst] = 1'b0;
      @(negedge clk);
      set_idle();
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : stim
      logic [4:0] hist[8];
      void'($urandom(32'd20240611));
      model_reset();
      for (int i = 0; i < 8; i++) hist[i] = 5'(i);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      set_idle();
      step("R1 reset state");
      set_disp(5'd3, 1'b1, 5'd0, 1'b0, 5'd10, 1'b1); step("R1 empty producer table");
      set_disp(5'd10, 1'b1, 5'd0, 1'b0, 5'd11, 1'b1); step("R2 append on src0");
      set_disp(5'd5, 1'b1, 5'd11, 1'b1, 5'd12, 1'b1); step("R2 append on src1");
      set_disp(5'd20, 1'b1, 5'd0, 1'b0, 5'd13, 1'b1); step("R3 fresh lane");
      set_disp(5'd0, 1'b0, 5'd0, 1'b0, 5'd14, 1'b1); step("R3 fresh lane 2");
      set_disp(5'd0, 1'b0, 5'd0, 1'b0, 5'd15, 1'b1); step("R3 fresh lane 3");
      set_disp(5'd0, 1'b0, 5'd0, 1'b0, 5'd16, 1'b1); step("R3 stall all busy");
      set_disp(5'd0, 1'b0, 5'd0, 1'b0, 5'd16, 1'b1); step("R3 stall again");
      iss_pop = 4'b0111; step("R7 pop ready heads");
      iss_pop = 4'b0001; step("R7 pop ignored when not ready");
      step("R7 head unchanged");
      set_wb(5'd10); step("R5 writeback");
      step("R5 request after writeback");
      set_disp(5'd0, 1'b0, 5'd0, 1'b0, 5'd30, 1'b1); set_wb(5'd30); step("R5 clear wins");
      iss_pop = 4'b0010; step("R8 remove producer");
      set_disp(5'd30, 1'b1, 5'd0, 1'b0, 5'd31, 1'b1); step("R8 reader starts fresh chain");
      step("R5 busy source holds request low");
      set_disp(5'd0, 1'b0, 5'd0, 1'b0, 5'd25, 1'b1); step("R6 setup producer");
      for (int q = 0; q < NQ; q++) if (m_cnt[q] > 0 && m_d[q][0] == 5'd25) iss_pop[q] = 1'b1;
      step("R8 producer leaves");
      set_disp(5'd25, 1'b1, 5'd0, 1'b0, 5'd26, 1'b1); set_wb(5'd25); step("R6 same cycle writeback");
      step("R6 request next cycle");
      for (int t = 0; t < 40; t++) begin
         set_wb(5'(t % NR)); iss_pop = '1; step("R7 drain");
      end
      set_disp(5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1); step("R9 chain start");
      for (int k = 1; k <= DP; k++) begin
         set_disp(5'(k - 1), 1'b1, 5'd0, 1'b0, 5'(k), 1'b1); step("R9 chain fill");
      end
      step("R9 overflow lane check");
      for (int n = 0; n < 2500; n++) begin
         if ($urandom % 10 < 7) begin
            logic [4:0] s0, s1, d;
            s0 = ($urandom % 3 == 0) ? 5'($urandom) : hist[$urandom % 8];
            s1 = ($urandom % 3 == 0) ? 5'($urandom) : hist[$urandom % 8];
            d  = 5'($urandom);
            set_disp(s0, 1'($urandom), s1, 1'($urandom), d, ($urandom % 8) != 0);
            for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = d;
         end
         if ($urandom % 10 < 5) set_wb(($urandom % 2 == 0) ? hist[$urandom % 8] : 5'($urandom));
         iss_pop = 4'($urandom);
         step("R2 R4 R9 random");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule